// File: doc/BRIEF.md
# Masked Packed Double-Precision Square Root Unit

This unit takes a 512-bit vector of up to eight IEEE-754 binary64 values and returns the square root of every lane that the operation enables. It has one iterative root engine that produces one root bit per clock by restoring recurrence. The engine serves the lanes one after another, starting at lane 0. Lanes that the writemask disables, and operands with a fixed answer (zero, infinity, NaN, negative), do not use the engine.

The decode stage supplies several fields with each request:
- the vector length;
- the encoding class, which decides how bits above the vector length are treated;
- a writemask and the choice between merge and zero masking;
- a broadcast bit, and whether the source came from memory;
- a global rounding mode and an embedded rounding mode;
- a 4-bit spare register field, which must be all ones;
- the old destination value.

The caller pulses `start` while `busy` is low and reads `result` when `done` pulses. The exception flags are sticky and are cleared only by reset.

Top module: `pd_sqrt_unit`

## Requirements
- R1: `vecLen` selects the active lane count: 0 gives 2 lanes (128 bits), 1 gives 4 lanes (256 bits), 2 or 3 gives 8 lanes (512 bits). Lane j occupies result bits [64j+63:64j]. For `encClass` 1 (unmasked class) or 2/3 (masked class), result bits above the vector length are zero.
- R2: With `encClass` 0 (legacy class), exactly lanes 0 and 1 are computed, whatever `vecLen` is. Result bits above 127 equal `oldDst`.
- R3: In the masked class with `maskEn`=1, a lane whose `wrMask` bit is 0 keeps its `oldDst` value when `zeroMask`=0 and becomes zero when `zeroMask`=1. With `maskEn`=0, or in any other class, every active lane is computed and the mask is ignored.
- R4: In the masked class with `bcastBit`=1 and `srcIsMem`=1, every active lane takes the root of `srcVec[63:0]`. In any other case each lane takes the root of its own source lane.
- R5: The rounding mode is `rmEmbed` only in the masked class with 8 lanes, `bcastBit`=1 and `srcIsMem`=0. In every other case it is `rmGlobal`.
- R6: Rounding encoding: 0 rounds to nearest-even, 1 rounds toward minus infinity, 2 rounds toward plus infinity, 3 rounds toward zero. Every finite positive root is correctly rounded in the selected mode.
- R7: Special operands have fixed results:
  - +0 and -0 return themselves;
  - +infinity returns +infinity;
  - a quiet NaN (exponent all ones, fraction bit 51 set) passes through unchanged;
  - a signaling NaN, or any negative nonzero non-NaN operand, returns 0xFFF8000000000000.
- R8: A subnormal operand is normalized before the recurrence, so its root comes out exact or correctly rounded.
- R9: Each flag is sticky until reset and is set only by lanes that are computed:
  - `flagInvalid` for a signaling NaN or a negative nonzero non-NaN operand;
  - `flagPrecision` for an inexact root;
  - `flagDenormal` for a subnormal operand.
- R10: When `extReg` is not 4'b1111 at `start`, `done` follows on the next cycle with `udFault`=1. `result` then equals `oldDst` and no flag changes. A later accepted request with `extReg`=4'b1111 clears `udFault`.
- R11: Handshake and reset:
  - after reset, `busy`, `done`, the flags, `udFault` and `result` are all zero;
  - a `start` seen while idle raises `busy` on the next cycle, and a `start` seen while busy is ignored;
  - `done` is a one-cycle pulse, and `result` holds its value while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| vecLen | input | 2 | Vector length select |
| encClass | input | 2 | 0 legacy, 1 unmasked, 2/3 masked class |
| srcIsMem | input | 1 | Source operand came from memory |
| bcastBit | input | 1 | Broadcast / embedded-rounding bit |
| maskEn | input | 1 | Writemask in use |
| wrMask | input | 8 | Per-lane writemask |
| zeroMask | input | 1 | 1 zeroing masking, 0 merging |
| rmGlobal | input | 2 | Global rounding mode |
| rmEmbed | input | 2 | Embedded rounding mode |
| extReg | input | 4 | Spare register field, must be 4'b1111 |
| srcVec | input | 512 | Source lanes |
| oldDst | input | 512 | Previous destination value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 512 | Destination vector |
| flagInvalid | output | 1 | Sticky invalid flag |
| flagPrecision | output | 1 | Sticky inexact flag |
| flagDenormal | output | 1 | Sticky subnormal-operand flag |
| udFault | output | 1 | Undefined-encoding fault of the last request |

## Verification
- **Square-root core.** A table of operands is rotated across all eight lanes. It mixes perfect squares, irrational roots, both zeros, infinity, quiet and signaling NaNs, negative values and subnormals. This separates the exact path from the rounded path, and the special-case bypass from the engine, in every lane position.
- **Rounding.** Two operands, one whose nearest root lies above the true value and one whose nearest root lies below it, are run under every rounding mode. This tells the four rounding modes apart and shows which mode is selected, global or embedded.
- **Masking, broadcast and upper bits.** Each masking and class pattern uses an `oldDst` that differs from lane to lane. Merging, zeroing, ignored masks, kept upper bits and cleared upper bits therefore all give different results.
- **Broadcast source.** Lane 0 holds a different value from the other lanes, so broadcasting can be told apart from per-lane reads.

// File: rtl/pd_sqrt_pkg.sv
package pd_sqrt_pkg;

  localparam int unsigned LANE_W    = 64;
  localparam int unsigned SIG_W     = 53;
  localparam int unsigned ROOT_BITS = SIG_W + 1;   // significand plus guard bit
  localparam logic [63:0] QNAN_DEFAULT = 64'hFFF8_0000_0000_0000;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_DOWN = 2'd1,
    RM_UP   = 2'd2,
    RM_ZERO = 2'd3
  } roundMode_e;

  typedef struct packed {
    logic load;
    logic engInit;
    logic engStep;
    logic commitCalc;
    logic commitSpecial;
    logic commitMasked;
  } sqrtStrobe_t;

endpackage

// File: rtl/pd_sqrt_ctrl.sv
module pd_sqrt_ctrl
  import pd_sqrt_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned ITERS = ROOT_BITS
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic                         faultIn,
  input  logic [$clog2(LANES+1)-1:0]   laneCnt,
  input  logic                         laneOn,
  input  logic                         laneSpecial,
  output sqrtStrobe_t                  strb,
  output logic [$clog2(LANES+1)-1:0]   laneIdx,
  output logic                         busy,
  output logic                         done
);
  localparam int unsigned LCW = $clog2(LANES + 1);
  localparam int unsigned ITW = $clog2(ITERS);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_RUN, S_WRITE, S_FIN} state_e;

  state_e         state;
  logic [ITW-1:0] iter;
  logic           laneEnd;

  assign laneEnd = (laneIdx == laneCnt);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FIN);

  always_comb begin
    strb = '0;
    case (state)
      S_IDLE:  strb.load = start;
      S_SCAN: begin
        strb.commitMasked  = !laneEnd && !laneOn;
        strb.commitSpecial = !laneEnd && laneOn && laneSpecial;
        strb.engInit       = !laneEnd && laneOn && !laneSpecial;
      end
      S_RUN:   strb.engStep = 1'b1;
      S_WRITE: strb.commitCalc = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      laneIdx <= '0;
      iter    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          laneIdx <= '0;
          state   <= faultIn ? S_FIN : S_SCAN;
        end
        S_SCAN: begin
          if (laneEnd) state <= S_FIN;
          else if (!laneOn || laneSpecial) laneIdx <= laneIdx + LCW'(1);
          else begin
            iter  <= '0;
            state <= S_RUN;
          end
        end
        S_RUN: begin
          iter <= iter + ITW'(1);
          if (iter == ITW'(ITERS - 1)) state <= S_WRITE;
        end
        S_WRITE: begin
          laneIdx <= laneIdx + LCW'(1);
          state   <= S_SCAN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pd_sqrt_datapath.sv
module pd_sqrt_datapath
  import pd_sqrt_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  sqrtStrobe_t                  strb,
  input  logic [$clog2(LANES+1)-1:0]   laneIdx,
  input  logic [1:0]                   vecLen,
  input  logic [1:0]                   encClass,
  input  logic                         srcIsMem,
  input  logic                         bcastBit,
  input  logic                         maskEn,
  input  logic [LANES-1:0]             wrMask,
  input  logic                         zeroMask,
  input  logic [1:0]                   rmGlobal,
  input  logic [1:0]                   rmEmbed,
  input  logic [3:0]                   extReg,
  input  logic [LANES*LANE_W-1:0]      srcVec,
  input  logic [LANES*LANE_W-1:0]      oldDst,
  output logic                         faultIn,
  output logic [$clog2(LANES+1)-1:0]   laneCnt,
  output logic                         laneOn,
  output logic                         laneSpecial,
  output logic [LANES*LANE_W-1:0]      result,
  output logic                         flagInvalid,
  output logic                         flagPrecision,
  output logic                         flagDenormal,
  output logic                         udFault
);
  localparam int unsigned VW   = LANES * LANE_W;
  localparam int unsigned LW   = $clog2(LANES);
  localparam int unsigned LCW  = $clog2(LANES + 1);
  localparam int unsigned QW   = ROOT_BITS;
  localparam int unsigned RADW = 2 * QW;
  localparam int unsigned REMW = QW + 3;

  // ---- request decode at start ----
  logic           isLegacy, isMaskCls;
  logic [LCW-1:0] cntIn;
  logic [VW-1:0]  preload;

  assign faultIn   = (extReg != 4'b1111);
  assign isLegacy  = (encClass == 2'd0);
  assign isMaskCls = encClass[1];
  assign cntIn     = (isLegacy || vecLen == 2'd0) ? LCW'(LANES / 4) :
                     (vecLen == 2'd1)             ? LCW'(LANES / 2) : LCW'(LANES);

  for (genvar j = 0; j < LANES; j++) begin : g_preload
    assign preload[j*LANE_W +: LANE_W] =
      ((j < cntIn) || isLegacy || faultIn) ? oldDst[j*LANE_W +: LANE_W] : '0;
  end

  logic [VW-1:0]    srcReg;
  logic [LANES-1:0] cfgOn;
  logic             cfgZero, cfgBcast;
  roundMode_e       cfgRm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg   <= '0;
      cfgOn    <= '0;
      laneCnt  <= '0;
      cfgZero  <= 1'b0;
      cfgBcast <= 1'b0;
      cfgRm    <= RM_NEAR;
    end else if (strb.load) begin
      srcReg   <= srcVec;
      cfgOn    <= (isMaskCls && maskEn) ? wrMask : '1;
      laneCnt  <= cntIn;
      cfgZero  <= zeroMask;
      cfgBcast <= isMaskCls && bcastBit && srcIsMem;
      cfgRm    <= roundMode_e'((isMaskCls && vecLen[1] && bcastBit && !srcIsMem) ? rmEmbed : rmGlobal);
    end
  end

  // ---- current lane operand and classification ----
  logic [LW-1:0]     lane;
  logic [LANE_W-1:0] op;
  logic              sgn, isNan, isSnan, isInf, isZero, isDen, specInv;
  logic [10:0]       ex;
  logic [51:0]       fr;
  logic [LANE_W-1:0] specVal;

  assign lane   = laneIdx[LW-1:0];
  assign op     = cfgBcast ? srcReg[LANE_W-1:0] : srcReg[{lane, 6'b0} +: LANE_W];
  assign {sgn, ex, fr} = op;
  assign laneOn = cfgOn[lane];
  assign isNan  = (ex == 11'h7FF) && (fr != '0);
  assign isSnan = isNan && !fr[51];
  assign isInf  = (ex == 11'h7FF) && (fr == '0);
  assign isZero = (ex == '0) && (fr == '0);
  assign isDen  = (ex == '0) && (fr != '0);
  assign laneSpecial = isNan || isInf || isZero || sgn;
  assign specInv = isSnan || (sgn && !isZero && !isNan);
  assign specVal = (isSnan || specInv) ? QNAN_DEFAULT : op;

  // ---- root engine: restoring recurrence, one bit per cycle ----
  function automatic logic [5:0] normShift(input logic [51:0] f);
    normShift = '0;
    for (int i = 0; i < 52; i++) if (f[i]) normShift = 6'(52 - i);
  endfunction

  logic [5:0]        sh;
  logic signed [12:0] eIn, shS;
  logic [SIG_W-1:0]  mantIn;
  logic [QW-1:0]     radIn;
  logic [12:0]       expOut;
  logic [RADW-1:0]   radReg;
  logic [REMW-1:0]   remReg, remSh, trial;
  logic [QW-1:0]     qReg;
  logic [10:0]       expReg;

  assign sh     = normShift(fr);
  assign shS    = signed'({7'b0, sh});
  assign eIn    = isDen ? (-13'sd1022 - shS) : (signed'({2'b0, ex}) - 13'sd1023);
  assign mantIn = isDen ? ({1'b0, fr} << sh) : {1'b1, fr};
  assign radIn  = eIn[0] ? {mantIn, 1'b0} : {1'b0, mantIn};
  assign expOut = 13'((eIn >>> 1) + 13'sd1023);
  assign remSh  = {remReg[REMW-3:0], radReg[RADW-1 -: 2]};
  assign trial  = {1'b0, qReg, 2'b01};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      radReg <= '0;
      remReg <= '0;
      qReg   <= '0;
      expReg <= '0;
    end else if (strb.engInit) begin
      radReg <= {radIn, {QW{1'b0}}};
      remReg <= '0;
      qReg   <= '0;
      expReg <= expOut[10:0];
    end else if (strb.engStep) begin
      radReg <= radReg << 2;
      if (remSh >= trial) begin
        remReg <= remSh - trial;
        qReg   <= {qReg[QW-2:0], 1'b1};
      end else begin
        remReg <= remSh;
        qReg   <= {qReg[QW-2:0], 1'b0};
      end
    end
  end

  // ---- rounding of the finished root ----
  logic guardB, stickyB, incB;
  logic [LANE_W-1:0] calcVal;

  assign guardB  = qReg[0];
  assign stickyB = (remReg != '0);
  always_comb begin
    case (cfgRm)
      RM_NEAR: incB = guardB && (stickyB || qReg[1]);
      RM_UP:   incB = guardB || stickyB;
      default: incB = 1'b0;
    endcase
  end
  assign calcVal = {1'b0, expReg, qReg[QW-2:1]} + LANE_W'(incB);

  // ---- destination and flags ----
  always_ff @(posedge clk) begin
    if (!rstN) begin
      result        <= '0;
      flagInvalid   <= 1'b0;
      flagPrecision <= 1'b0;
      flagDenormal  <= 1'b0;
      udFault       <= 1'b0;
    end else begin
      if (strb.load) begin
        result  <= preload;
        udFault <= faultIn;
      end
      if (strb.commitMasked && cfgZero) result[{lane, 6'b0} +: LANE_W] <= '0;
      if (strb.commitSpecial) begin
        result[{lane, 6'b0} +: LANE_W] <= specVal;
        flagInvalid  <= flagInvalid | specInv;
        flagDenormal <= flagDenormal | isDen;
      end
      if (strb.engInit) flagDenormal <= flagDenormal | isDen;
      if (strb.commitCalc) begin
        result[{lane, 6'b0} +: LANE_W] <= calcVal;
        flagPrecision <= flagPrecision | guardB | stickyB;
      end
    end
  end
endmodule

// File: rtl/pd_sqrt_unit.sv
module pd_sqrt_unit
  import pd_sqrt_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [1:0]              vecLen,
  input  logic [1:0]              encClass,
  input  logic                    srcIsMem,
  input  logic                    bcastBit,
  input  logic                    maskEn,
  input  logic [LANES-1:0]        wrMask,
  input  logic                    zeroMask,
  input  logic [1:0]              rmGlobal,
  input  logic [1:0]              rmEmbed,
  input  logic [3:0]              extReg,
  input  logic [LANES*64-1:0]     srcVec,
  input  logic [LANES*64-1:0]     oldDst,
  output logic                    busy,
  output logic                    done,
  output logic [LANES*64-1:0]     result,
  output logic                    flagInvalid,
  output logic                    flagPrecision,
  output logic                    flagDenormal,
  output logic                    udFault
);
  localparam int unsigned LCW = $clog2(LANES + 1);

  sqrtStrobe_t    strb;
  logic [LCW-1:0] laneIdx, laneCnt;
  logic           laneOn, laneSpecial, faultIn;

  pd_sqrt_ctrl #(.LANES(LANES), .ITERS(ROOT_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .faultIn(faultIn),
    .laneCnt(laneCnt), .laneOn(laneOn), .laneSpecial(laneSpecial),
    .strb(strb), .laneIdx(laneIdx), .busy(busy), .done(done)
  );

  pd_sqrt_datapath #(.LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .laneIdx(laneIdx),
    .vecLen(vecLen), .encClass(encClass), .srcIsMem(srcIsMem), .bcastBit(bcastBit),
    .maskEn(maskEn), .wrMask(wrMask), .zeroMask(zeroMask),
    .rmGlobal(rmGlobal), .rmEmbed(rmEmbed), .extReg(extReg),
    .srcVec(srcVec), .oldDst(oldDst),
    .faultIn(faultIn), .laneCnt(laneCnt), .laneOn(laneOn), .laneSpecial(laneSpecial),
    .result(result), .flagInvalid(flagInvalid), .flagPrecision(flagPrecision),
    .flagDenormal(flagDenormal), .udFault(udFault)
  );
endmodule

// File: rtl/pd_sqrt_unit_chk.sv
module pd_sqrt_unit_chk #(
  parameter int unsigned LANES = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic [3:0]          extReg,
  input logic                busy,
  input logic                done,
  input logic [LANES*64-1:0] result,
  input logic                flagInvalid,
  input logic                flagPrecision,
  input logic                flagDenormal,
  input logic                udFault
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN) (start && !busy) |=> busy);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN) (!busy && !start) |=> $stable(result));
  // R10
  fault_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && extReg != 4'b1111) |=> (done && udFault));
  // R9
  inv_sticky_chk: assert property (@(posedge clk) disable iff (!rstN) flagInvalid |=> flagInvalid);
  // R9
  prec_sticky_chk: assert property (@(posedge clk) disable iff (!rstN) flagPrecision |=> flagPrecision);
  // R9
  den_sticky_chk: assert property (@(posedge clk) disable iff (!rstN) flagDenormal |=> flagDenormal);
endmodule

bind pd_sqrt_unit pd_sqrt_unit_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .extReg(extReg), .busy(busy), .done(done),
  .result(result), .flagInvalid(flagInvalid), .flagPrecision(flagPrecision),
  .flagDenormal(flagDenormal), .udFault(udFault)
);

// File: tb/pd_sqrt_unit_tb.sv
module pd_sqrt_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  localparam logic [63:0] F_1   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] F_2   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] F_3   = 64'h4008_0000_0000_0000;
  localparam logic [63:0] F_4   = 64'h4010_0000_0000_0000;
  localparam logic [63:0] F_9   = 64'h4022_0000_0000_0000;
  localparam logic [63:0] F_16  = 64'h4030_0000_0000_0000;
  localparam logic [63:0] QNAN  = 64'hFFF8_0000_0000_0000;
  localparam logic [63:0] R2_HI = 64'h3FF6_A09E_667F_3BCD;
  localparam logic [63:0] R2_LO = 64'h3FF6_A09E_667F_3BCC;
  localparam logic [63:0] R3_HI = 64'h3FFB_B67A_E858_4CAB;
  localparam logic [63:0] R3_LO = 64'h3FFB_B67A_E858_4CAA;

  // operand, nearest-even root
  localparam logic [127:0] VEC [NV] = '{
    {F_4, F_2}, {F_1, F_1}, {F_2, R2_HI}, {F_9, F_3},
    {64'h3FD0_0000_0000_0000, 64'h3FE0_0000_0000_0000},
    {64'h0, 64'h0}, {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
    {64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000},
    {64'hBFF0_0000_0000_0000, QNAN},
    {64'h7FF8_0000_0000_0001, 64'h7FF8_0000_0000_0001},
    {64'h7FF0_0000_0000_0001, QNAN},
    {64'h0000_0000_0000_0001, 64'h1E60_0000_0000_0000},
    {64'h0000_0000_0000_0004, 64'h1E70_0000_0000_0000},
    {F_16, F_4}
  };

  logic clk = 0, rstN = 0, start = 0;
  logic [1:0] vecLen = 0, encClass = 0, rmGlobal = 0, rmEmbed = 0;
  logic srcIsMem = 0, bcastBit = 0, maskEn = 0, zeroMask = 0;
  logic [7:0] wrMask = 0;
  logic [3:0] extReg = 4'hF;
  logic [511:0] srcVec = '0, oldDst = '0;
  logic busy, done, flagInvalid, flagPrecision, flagDenormal, udFault;
  logic [511:0] result;
  logic [511:0] oldPat, expV, srcV;
  int checks = 0, failures = 0, cycles = 0;

  pd_sqrt_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen), .encClass(encClass),
    .srcIsMem(srcIsMem), .bcastBit(bcastBit), .maskEn(maskEn), .wrMask(wrMask),
    .zeroMask(zeroMask), .rmGlobal(rmGlobal), .rmEmbed(rmEmbed), .extReg(extReg),
    .srcVec(srcVec), .oldDst(oldDst), .busy(busy), .done(done), .result(result),
    .flagInvalid(flagInvalid), .flagPrecision(flagPrecision),
    .flagDenormal(flagDenormal), .udFault(udFault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL R11 watchdog got=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [511:0] got, input logic [511:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic setOp(input logic [1:0] vl, input logic [1:0] enc, input logic mem,
                       input logic bc, input logic me, input logic [7:0] mk,
                       input logic zm, input logic [1:0] rg, input logic [1:0] re);
    vecLen = vl; encClass = enc; srcIsMem = mem; bcastBit = bc; maskEn = me;
    wrMask = mk; zeroMask = zm; rmGlobal = rg; rmEmbed = re; extReg = 4'hF;
  endtask

  task automatic fire();
    int n;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      failures++;
      $display("FAIL R11 done missing got=0 expected=1");
    end
  endtask

  function automatic logic [511:0] laneMix(input logic [7:0] m, input logic [63:0] onV,
                                           input logic [511:0] offV);
    logic [511:0] r;
    for (int j = 0; j < 8; j++) r[j*64 +: 64] = m[j] ? onV : offV[j*64 +: 64];
    return r;
  endfunction

  initial begin
    for (int j = 0; j < 8; j++) oldPat[j*64 +: 64] = 64'hA5A5_0000_0000_0000 + 64'(j);
    oldDst = oldPat;
    doReset();

    // R11 reset state
    chk("R11 reset busy/done/flags/fault",
        512'({busy, done, flagInvalid, flagPrecision, flagDenormal, udFault}), '0);
    chk("R11 reset result", result, '0);

    // R6 R7 R8 table walk: masked class, 8 lanes, no mask, nearest-even
    for (int i = 0; i < NV; i++) begin
      setOp(2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0);
      for (int j = 0; j < 8; j++) begin
        srcV[j*64 +: 64] = VEC[(i + j) % NV][127:64];
        expV[j*64 +: 64] = VEC[(i + j) % NV][63:0];
      end
      srcVec = srcV;
      fire();
      chk($sformatf("R6/R7/R8 table row %0d", i), result, expV);
    end

    // R9 flags: exact roots leave precision clear; inexact sets it; sticky
    doReset();
    setOp(2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0);
    srcVec = {8{F_4}}; fire();
    chk("R9 exact roots raise no flag", 512'({flagInvalid, flagPrecision, flagDenormal}), '0);
    srcVec = {8{F_2}}; fire();
    chk("R9 inexact root sets precision", 512'(flagPrecision), 512'(1));
    srcVec = {8{F_4}}; fire();
    chk("R9 precision stays set", 512'(flagPrecision), 512'(1));

    // R8 R9 subnormal operand
    doReset();
    srcVec = {8{64'h0000_0000_0000_0001}}; fire();
    chk("R8 subnormal root", result, {8{64'h1E60_0000_0000_0000}});
    chk("R9 denormal flag", 512'({flagInvalid, flagDenormal}), 512'(2'b01));

    // R3 merge and zero masking
    doReset();
    setOp(2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, 2'd0, 2'd0);
    srcVec = {8{F_4}}; fire();
    chk("R3 merge masking", result, laneMix(8'hA5, F_2, oldPat));
    zeroMask = 1'b1; fire();
    chk("R3 zero masking", result, laneMix(8'hA5, F_2, '0));

    // R9 masked-off sNaN lane raises nothing; enabled lane does
    zeroMask = 1'b0; wrMask = 8'hFE;
    srcVec = {{7{F_4}}, 64'h7FF0_0000_0000_0001}; fire();
    chk("R9 masked sNaN lane no invalid", 512'(flagInvalid), '0);
    chk("R3 masked lane 0 merged", result, laneMix(8'hFE, F_2, oldPat));
    wrMask = 8'hFF; fire();
    chk("R9 active sNaN lane sets invalid", 512'(flagInvalid), 512'(1));

    // R4 broadcast from memory vs register source vs unmasked class
    setOp(2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0);
    srcVec = {{7{F_16}}, F_9}; fire();
    chk("R4 memory broadcast", result, {8{F_3}});
    srcIsMem = 1'b0; fire();
    chk("R4 register source no broadcast", result, {{7{F_4}}, F_3});
    setOp(2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0); fire();
    chk("R4/R1 unmasked class no broadcast, upper zero", result, {256'h0, {3{F_4}}, F_3});

    // R5 embedded rounding only for 512-bit register form
    setOp(2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 2'd3);
    srcVec = {8{F_2}}; fire();
    chk("R5 embedded toward-zero used", result, {8{R2_LO}});
    vecLen = 2'd1; fire();
    chk("R5 256-bit ignores embedded", result, {256'h0, {4{R2_HI}}});
    vecLen = 2'd2; srcIsMem = 1'b1; fire();
    chk("R5 memory form ignores embedded", result, {8{R2_HI}});

    // R6 each global rounding mode, 128-bit masked class
    srcVec = {{6{F_4}}, F_3, F_2};
    setOp(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0); fire();
    chk("R6 nearest-even", result, {384'h0, R3_LO, R2_HI});
    rmGlobal = 2'd1; fire();
    chk("R6 toward minus infinity", result, {384'h0, R3_LO, R2_LO});
    rmGlobal = 2'd2; fire();
    chk("R6 toward plus infinity", result, {384'h0, R3_HI, R2_HI});
    rmGlobal = 2'd3; fire();
    chk("R6/R1 toward zero, upper zero", result, {384'h0, R3_LO, R2_LO});

    // R3 R1 unmasked class ignores mask
    setOp(2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 2'd0, 2'd0);
    srcVec = {8{F_4}}; fire();
    chk("R3 unmasked class ignores mask", result, {384'h0, F_2, F_2});

    // R2 legacy class keeps upper bits
    setOp(2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0); fire();
    chk("R2 legacy upper preserved", result, {oldPat[511:128], F_2, F_2});

    // R10 fault
    doReset();
    setOp(2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0);
    srcVec = {8{F_2}}; extReg = 4'b0111; fire();
    chk("R10 fault flag", 512'(udFault), 512'(1));
    chk("R10 fault leaves old dest", result, oldPat);
    chk("R10 fault changes no flag", 512'({flagInvalid, flagPrecision, flagDenormal}), '0);
    extReg = 4'hF; fire();
    chk("R10 fault cleared by good request", 512'(udFault), '0);

    // R11 start while busy is ignored
    srcVec = {8{F_9}};
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (5) @(negedge clk);
    chk("R11 busy while running", 512'(busy), 512'(1));
    srcVec = {8{F_16}};
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    srcVec = {8{F_4}};
    while (!done) @(negedge clk);
    chk("R11 second start ignored", result, {8{F_3}});
    @(negedge clk);
    chk("R11 done is one cycle", 512'(done), '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule